// File: doc/BRIEF.md
# Mixed-Length Instruction Splitter

This block takes one fetch group of eight 16-bit parcels per cycle and cuts it into instructions, for an instruction stream where 16-bit and 32-bit encodings are freely mixed and a 32-bit instruction may start on any parcel. The group is handled by a row of identical slices. Each slice owns two parcels and can also see the last parcel of its left neighbour. A single boundary flag runs from slice to slice. It tells the next slice whether the parcel it shares starts a 32-bit instruction that still needs its upper half.

The flag that leaves the last slice is held in a register, together with the group's final parcel. An instruction split across two fetch groups therefore comes out whole with the next valid group. The results are packed into up to eight slots in program order. Each slot has a valid bit, a size bit, an illegal flag and a 32-bit word. A redirect drops the held state and can start decoding at any parcel offset within the group. Slot outputs are combinational from the current fetch inputs and the held state.

Top module: `psplit_top`

## Requirements
- R1: A parcel whose bits [1:0] are not 2'b11 is a complete 16-bit instruction: its slot has size bit 0 and the parcel in word bits [15:0], with bits [31:16] zero.
- R2: Valid slots are packed from slot 0 upward with no gaps, in the order the instructions appear in the group. Parcel 0 is data bits [15:0] and parcel 7 is data bits [127:112].
- R3: A parcel at an even offset with bits [1:0] equal to 2'b11 starts an aligned 32-bit instruction: size bit 1, word = {next parcel, this parcel}.
- R4: A 32-bit instruction starting at an odd parcel inside the group is emitted as one slot whose word is {following parcel, starting parcel}.
- R5: A 32-bit instruction starting at parcel 7 is not emitted with its own group. The first slot of the next valid group is {new parcel 0, held parcel 7}.
- R6: A valid group without redirect yields between 4 and 8 slots.
- R7: While fetch_valid is low, no slot is valid and the held boundary state is unchanged. After reset, no state is held.
- R8: When redirect and fetch_valid are high together, any held half instruction is discarded and parcels below redir_off are ignored.
- R9: A redirect while fetch_valid is low clears the held half instruction, so parcel 0 of the next group is decoded as an instruction start.
- R10: A starting parcel whose bits [4:0] are 5'b11111 (an encoding of 48 bits or more) is emitted as a 32-bit slot with the illegal flag set, covering that parcel and the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch group present this cycle |
| fetch_data | input | 128 | Eight parcels, parcel 0 in the low bits |
| redir | input | 1 | Redirect: drop held state; with fetch_valid, apply redir_off |
| redir_off | input | 3 | Parcel offset of the redirect target |
| slot_vld | output | 8 | Slot valid bits |
| slot_big | output | 8 | Slot holds a 32-bit instruction |
| slot_ill | output | 8 | Slot holds an over-long (illegal) encoding |
| slot_word | output | 256 | Slot words, slot 0 in the low 32 bits |

## Verification
A wrong boundary flag inside the row of slices shows in the same cycle. Every slot after the faulty point either shifts by one parcel or comes out with the wrong size, so the packed slot sequence no longer matches. A wrong held flag or held parcel shows only with the next valid group, as a missing or wrongly joined first slot. The bench therefore puts idle and redirect cycles between groups that end in a split instruction.

// File: rtl/psplit_pkg.sv
package psplit_pkg;
  localparam int PARCEL_W = 16;
  localparam int INSN_W   = 2 * PARCEL_W;

  typedef struct packed {
    logic              vld;
    logic              big;
    logic              ill;
    logic [INSN_W-1:0] word;
  } slot_t;

  function automatic logic starts_wide(input logic [PARCEL_W-1:0] p);
    return p[1:0] == 2'b11;
  endfunction

  function automatic logic starts_overlong(input logic [PARCEL_W-1:0] p);
    return p[4:0] == 5'b11111;
  endfunction

  function automatic slot_t mk_short(input logic [PARCEL_W-1:0] p);
    slot_t s;
    s.vld  = 1'b1;
    s.big  = 1'b0;
    s.ill  = 1'b0;
    s.word = {{PARCEL_W{1'b0}}, p};
    return s;
  endfunction

  function automatic slot_t mk_wide(input logic [PARCEL_W-1:0] lo,
                                    input logic [PARCEL_W-1:0] hi);
    slot_t s;
    s.vld  = 1'b1;
    s.big  = 1'b1;
    s.ill  = starts_overlong(lo);
    s.word = {hi, lo};
    return s;
  endfunction
endpackage

// File: rtl/psplit_slice.sv
module psplit_slice
  import psplit_pkg::*;
(
  input  logic [PARCEL_W-1:0] prev_p,
  input  logic [PARCEL_W-1:0] p0,
  input  logic [PARCEL_W-1:0] p1,
  input  logic                m0,
  input  logic                m1,
  input  logic                cin,
  output slot_t               slot_lo,
  output slot_t               slot_hi,
  output logic                cout
);
  always_comb begin
    slot_lo = '0;
    slot_hi = '0;
    cout    = 1'b0;
    if (cin) begin
      slot_lo = mk_wide(prev_p, p0);
      if (m1) begin
        if (starts_wide(p1)) cout = 1'b1;
        else                 slot_hi = mk_short(p1);
      end
    end else if (m0) begin
      if (starts_wide(p0)) begin
        slot_lo = mk_wide(p0, p1);
      end else begin
        slot_lo = mk_short(p0);
        if (starts_wide(p1)) cout = 1'b1;
        else                 slot_hi = mk_short(p1);
      end
    end else if (m1) begin
      if (starts_wide(p1)) cout = 1'b1;
      else                 slot_lo = mk_short(p1);
    end
  end
endmodule

// File: rtl/psplit_pack.sv
module psplit_pack
  import psplit_pkg::*;
#(
  parameter int NIN = 8
) (
  input  slot_t raw   [NIN],
  output slot_t dense [NIN]
);
  localparam int IDXW = $clog2(NIN + 1);

  always_comb begin
    logic [IDXW-1:0] idx;
    idx   = '0;
    dense = '{default: '0};
    for (int i = 0; i < NIN; i++) begin
      if (raw[i].vld) begin
        dense[idx] = raw[i];
        idx        = idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/psplit_top.sv
module psplit_top
  import psplit_pkg::*;
#(
  parameter int NSLICE = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            fetch_valid,
  input  logic [2*NSLICE*16-1:0]          fetch_data,
  input  logic                            redir,
  input  logic [$clog2(2*NSLICE)-1:0]     redir_off,
  output logic [2*NSLICE-1:0]             slot_vld,
  output logic [2*NSLICE-1:0]             slot_big,
  output logic [2*NSLICE-1:0]             slot_ill,
  output logic [2*NSLICE*32-1:0]          slot_word
);
  localparam int NPAR = 2 * NSLICE;
  localparam int OFFW = $clog2(NPAR);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [PARCEL_W-1:0] par [NPAR];
  logic [NPAR-1:0]     pmask;
  for (genvar j = 0; j < NPAR; j++) begin : g_par
    assign par[j]   = fetch_data[j*PARCEL_W +: PARCEL_W];
    assign pmask[j] = !redir || (OFFW'(j) >= redir_off);
  end

  // held boundary state
  logic                carry_q, carry_d, carry_en;
  logic [PARCEL_W-1:0] carry_par_q, carry_par_d;
  logic [NSLICE:0]     link;

  assign link[0] = carry_q & ~redir;

  slot_t raw   [NPAR];
  slot_t gated [NPAR];
  slot_t dense [NPAR];

  for (genvar k = 0; k < NSLICE; k++) begin : g_slice
    logic [PARCEL_W-1:0] prev_p;
    if (k == 0) begin : g_first
      assign prev_p = carry_par_q;
    end else begin : g_rest
      assign prev_p = par[2*k-1];
    end
    psplit_slice u_slice (
      .prev_p  (prev_p),
      .p0      (par[2*k]),
      .p1      (par[2*k+1]),
      .m0      (pmask[2*k]),
      .m1      (pmask[2*k+1]),
      .cin     (link[k]),
      .slot_lo (raw[2*k]),
      .slot_hi (raw[2*k+1]),
      .cout    (link[k+1])
    );
  end

  always_comb begin
    for (int i = 0; i < NPAR; i++) begin
      gated[i]     = raw[i];
      gated[i].vld = raw[i].vld & fetch_valid;
    end
  end

  psplit_pack #(.NIN(NPAR)) u_pack (
    .raw   (gated),
    .dense (dense)
  );

  for (genvar s = 0; s < NPAR; s++) begin : g_out
    assign slot_vld[s]                 = dense[s].vld;
    assign slot_big[s]                 = dense[s].big;
    assign slot_ill[s]                 = dense[s].ill;
    assign slot_word[s*INSN_W +: INSN_W] = dense[s].word;
  end

  // next-state
  always_comb begin
    carry_en    = fetch_valid | redir;
    carry_d     = carry_q;
    carry_par_d = carry_par_q;
    if (fetch_valid) begin
      carry_d     = link[NSLICE];
      carry_par_d = par[NPAR-1];
    end else if (redir) begin
      carry_d     = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      carry_q     <= 1'b0;
      carry_par_q <= '0;
    end else if (carry_en) begin
      carry_q     <= carry_d;
      carry_par_q <= carry_par_d;
    end
  end
endmodule

// File: rtl/psplit_chk.sv
module psplit_chk #(
  parameter int NSLICE = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  fetch_valid,
  input logic                  redir,
  input logic [2*NSLICE-1:0]   slot_vld,
  input logic [2*NSLICE-1:0]   slot_big,
  input logic [2*NSLICE-1:0]   slot_ill,
  input logic                  carry_q
);
  localparam int NPAR = 2 * NSLICE;

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |-> slot_vld == '0); // R7

  AST_CARRY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid && !redir) |=> $stable(carry_q)); // R7

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid && redir) |=> !carry_q); // R9

  AST_SLOTS_DENSE: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld & NPAR'(slot_vld + 1'b1)) == '0); // R2

  AST_MIN_YIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !redir) |-> $countones(slot_vld) >= NSLICE); // R6

  AST_ILL_IS_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_ill & ~(slot_big & slot_vld)) == '0); // R10
endmodule

bind psplit_top psplit_chk #(.NSLICE(NSLICE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_valid (fetch_valid),
  .redir       (redir),
  .slot_vld    (slot_vld),
  .slot_big    (slot_big),
  .slot_ill    (slot_ill),
  .carry_q     (carry_q)
);

// File: tb/test_psplit_top.sv
module test_psplit_top;
  localparam int CLK_PERIOD = 10;
  localparam int NPAR = 8;

  typedef logic [15:0] grp_t [NPAR];
  typedef struct {
    logic [31:0] word;
    logic        big;
    logic        ill;
    string       tag;
  } exp_t;
  typedef struct {
    int    n;
    logic  rd;
    string tag;
  } grp_info_t;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           fetch_valid;
  logic [127:0]   fetch_data;
  logic           redir;
  logic [2:0]     redir_off;
  logic [7:0]     slot_vld, slot_big, slot_ill;
  logic [255:0]   slot_word;

  int checks = 0;
  int errors = 0;

  exp_t      exp_q [$];
  grp_info_t grp_q [$];

  // reference model state: sequential parcel scan
  logic        m_pend;
  logic [15:0] m_par;

  always #(CLK_PERIOD/2) clk = ~clk;

  psplit_top i_psplit_top (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_data(fetch_data),
    .redir(redir), .redir_off(redir_off), .slot_vld(slot_vld), .slot_big(slot_big),
    .slot_ill(slot_ill), .slot_word(slot_word)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic send(input grp_t g, input bit rd, input int off, input string tag);
    logic        pend;
    logic [15:0] pp;
    int          n;
    exp_t        e;
    @(posedge clk); #1;
    fetch_valid = 1'b1;
    redir       = rd;
    redir_off   = 3'(off);
    for (int i = 0; i < NPAR; i++) fetch_data[i*16 +: 16] = g[i];
    pend = rd ? 1'b0 : m_pend;
    pp   = m_par;
    n    = 0;
    for (int i = 0; i < NPAR; i++) begin
      if (rd && i < off) continue;
      if (pend) begin
        e.word = {g[i], pp}; e.big = 1'b1; e.ill = (pp[4:0] == 5'h1f); e.tag = tag;
        exp_q.push_back(e); n++; pend = 1'b0;
      end else if (g[i][1:0] == 2'b11) begin
        pend = 1'b1; pp = g[i];
      end else begin
        e.word = {16'h0, g[i]}; e.big = 1'b0; e.ill = 1'b0; e.tag = tag;
        exp_q.push_back(e); n++;
      end
    end
    m_pend = pend;
    m_par  = g[NPAR-1];
    grp_q.push_back('{n, rd, tag});
  endtask

  task automatic idle(input bit rd);
    @(posedge clk); #1;
    fetch_valid = 1'b0;
    redir       = rd;
    fetch_data  = {8{16'hFFFF}};
    if (rd) m_pend = 1'b0;
  endtask

  // monitor: pops expected items as the design presents them
  always @(negedge clk) begin
    if (rst_n !== 1'b1) begin
      // nothing
    end else if (fetch_valid !== 1'b1) begin
      check(slot_vld == 8'h0, "R7", "idle slot_vld", 64'(slot_vld), 64'h0);
    end else if (grp_q.size() != 0) begin
      grp_info_t gi;
      gi = grp_q.pop_front();
      if (!gi.rd)
        check($countones(slot_vld) >= 4 && $countones(slot_vld) <= 8, "R6",
              "slot count", 64'($countones(slot_vld)), 64'(gi.n));
      for (int s = 0; s < NPAR; s++) begin
        if (s < gi.n) begin
          exp_t e;
          e = exp_q.pop_front();
          check(slot_vld[s] === 1'b1, {e.tag, " R2"}, $sformatf("slot %0d vld", s),
                64'(slot_vld[s]), 64'h1);
          check(slot_word[s*32 +: 32] === e.word && slot_big[s] === e.big &&
                slot_ill[s] === e.ill, e.tag, $sformatf("slot %0d {ill,big,word}", s),
                {30'h0, slot_ill[s], slot_big[s], slot_word[s*32 +: 32]},
                {30'h0, e.ill, e.big, e.word});
        end else begin
          check(slot_vld[s] === 1'b0, {gi.tag, " R2"}, $sformatf("slot %0d unused vld", s),
                64'(slot_vld[s]), 64'h0);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fetch_valid = 1'b0; redir = 1'b0; redir_off = '0; fetch_data = '0;
    m_pend = 1'b0; m_par = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(slot_vld == 8'h0, "R7", "reset slot_vld", 64'(slot_vld), 64'h0);

    // R1: all compressed, first group after reset (nothing held)
    send('{16'h0104, 16'h0205, 16'h0306, 16'h0400, 16'h0501, 16'h0602, 16'h0704, 16'h0808}, 0, 0, "R1 R7");
    // R3: all aligned wide
    send('{16'h1103, 16'hA001, 16'h2207, 16'hB002, 16'h330B, 16'hC003, 16'h440F, 16'hD004}, 0, 0, "R3 R6");
    // R4: misaligned wide instructions inside the group
    send('{16'h0010, 16'h5513, 16'hE005, 16'h0020, 16'h0031, 16'h6617, 16'hE006, 16'h0042}, 0, 0, "R4");
    // R5 + R7: split across groups with idle cycles between
    send('{16'h0050, 16'h0061, 16'h0072, 16'h0080, 16'h0091, 16'h00A2, 16'h00B0, 16'h7723}, 0, 0, "R5");
    idle(0);
    idle(0);
    send('{16'hF00D, 16'h0100, 16'h0201, 16'h0302, 16'h0400, 16'h0501, 16'h0602, 16'h0700}, 0, 0, "R5 R7");
    // R9: flush without data drops the held half
    send('{16'h0001, 16'h0002, 16'h0000, 16'h0001, 16'h0002, 16'h0000, 16'h0001, 16'h8827}, 0, 0, "R5");
    idle(1);
    send('{16'h5554, 16'h0001, 16'h0002, 16'h0000, 16'h0001, 16'h0002, 16'h0000, 16'h992B}, 0, 0, "R9");
    // R8: redirect with data at odd offset 3, held half pending
    send('{16'h0003, 16'h0007, 16'h000B, 16'h1230, 16'h1231, 16'h1232, 16'h1230, 16'h1231}, 1, 3, "R8");
    // R8: redirect at offset 1, first parcel wide
    send('{16'h0003, 16'hAB13, 16'hCDEF, 16'h0120, 16'hAB17, 16'hCD00, 16'h0121, 16'h0122}, 1, 1, "R8 R4");
    // R10: over-long encodings, aligned and misaligned
    send('{16'h001F, 16'h4444, 16'h0124, 16'h00FF, 16'h5555, 16'h0125, 16'h0126, 16'h0127}, 0, 0, "R10");
    // R10 across the group edge
    send('{16'h0130, 16'h0131, 16'h0132, 16'h0130, 16'h0131, 16'h0132, 16'h0130, 16'h003F}, 0, 0, "R10 R5");
    send('{16'h6666, 16'h0140, 16'h0141, 16'h0142, 16'h0140, 16'h0141, 16'h0142, 16'h0140}, 0, 0, "R10 R5");
    // R6: alternating wide pattern, misaligned chain through all slices
    send('{16'h0150, 16'h0153, 16'h0A00, 16'h0157, 16'h0B00, 16'h015B, 16'h0C00, 16'h0151}, 0, 0, "R4 R6");
    idle(0);
    @(negedge clk);
    @(negedge clk);
    check(exp_q.size() == 0 && grp_q.size() == 0, "R2", "scoreboard drained",
          64'(exp_q.size()), 64'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule